// File: doc/BRIEF.md
# Radio Front-End Warmup and Warmdown Sequencer

This block switches a bank of enable lines to a radio front end on and off in a programmed order while the radio powers up for transmit or receive and while it powers down afterwards. Each enable line owns one 32-bit timing word. The word holds separate switch-on and switch-off times for the transmit timeline and for the receive timeline. A shared end word gives the tick at which each warmup phase and each warmdown phase ends. All times are counted in ticks of an external 1 µs strobe, starting from the beginning of warmup.

A transmit or receive request from idle does three things: it copies the configuration into working registers, clears the tick counter and starts warmup. When the counter reaches the warmup end, the block signals ready and freezes both the counter and the outputs. A stop request then runs warmdown on the same timeline, continuing from the tick after the warmup end. At the warmdown end every enable line is forced low and the block returns to idle.

Top module: `radio_seq_ctrl`

## Requirements
- R1: Timing word layout. Bits 7:0 are the transmit switch-on time and bits 15:8 the transmit switch-off time. Bits 23:16 are the receive switch-on time and bits 31:24 the receive switch-off time. Only the half that matches the running mode is used.
- R2: A time field of 0xFF suppresses that edge. If the switch-on and switch-off times are equal, the line stays low because switch-off wins.
- R3: Times are evaluated only in cycles where tick_i is high during warmup or warmdown. On such a cycle, a line matching its switch-on time goes high at the next clock edge and a line matching its switch-off time goes low. The counter starts at 0 when a sequence starts and advances by one per evaluated tick. Outputs never change in a cycle without a tick.
- R4: On the tick where the counter equals the warmup end, the edges for that tick are applied and the state becomes ACTIVE. In ACTIVE, ready_o is high, the counter holds, and further ticks change nothing.
- R5: stop_req_i is accepted only in ACTIVE and starts WARMDOWN. Warmdown evaluation continues from warmup end plus one. A stop request in any other state is ignored.
- R6: On the tick where the counter equals the warmdown end, all enable lines go low and the state returns to IDLE. All lines are low whenever the state is IDLE.
- R7: tx_req_i and rx_req_i are accepted only in IDLE. If both are high in the same cycle, the sequence runs in transmit mode.
- R8: A configuration write takes effect only at the next start from IDLE. A running sequence keeps the values copied at its start.
- R9: After reset the state is IDLE (state_o 0), ready_o is low and all lines are low. Every timing word resets to all ones and the end word resets to 0. The state_o encoding is IDLE=0, WARMUP=1, ACTIVE=2, WARMDOWN=3.
- R10: Write address i below NUM_SIG selects the timing word of line i. Address NUM_SIG selects the end word, whose layout is: bits 7:0 transmit warmup end, bits 15:8 transmit warmdown end, bits 23:16 receive warmup end, bits 31:24 receive warmdown end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(NUM_SIG+1) | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| tx_req_i | input | 1 | Start a transmit sequence |
| rx_req_i | input | 1 | Start a receive sequence |
| stop_req_i | input | 1 | Start warmdown from ACTIVE |
| tick_i | input | 1 | 1 µs timing strobe, one cycle wide |
| en_o | output | NUM_SIG | Enable lines to the front end |
| state_o | output | 2 | Sequencer state |
| ready_o | output | 1 | Warmup complete, outputs held |

## Verification
The bench runs one transmit and one receive sequence through a stepwise table. The sequences cover a one-tick pulse, a line with equal switch-on and switch-off times, lines with one half disabled, and a line that drops one tick into warmdown. A wrong layout decode or compare would show up as a pulse at the wrong tick, or as a pulse where none was programmed. The directed tests issue simultaneous requests, which a wrong priority would start in receive mode. They issue a second request and an early stop during warmup; a design that accepted either would switch timelines or start warmdown too soon. They pause without ticks, which exposes a free-running counter, and keep ticking in ACTIVE, which exposes a counter that does not freeze. They rewrite a word in the middle of a sequence; a design without a working snapshot would change the running pulse. The next sequence must then pick up the new word.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
  localparam int unsigned TIME_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam logic [TIME_W-1:0] EDGE_OFF = '1;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WARMUP   = 2'd1,
    ST_ACTIVE   = 2'd2,
    ST_WARMDOWN = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [TIME_W-1:0] rx_off;
    logic [TIME_W-1:0] rx_on;
    logic [TIME_W-1:0] tx_off;
    logic [TIME_W-1:0] tx_on;
  } sig_word_t;

  typedef struct packed {
    logic [TIME_W-1:0] rx_wd_end;
    logic [TIME_W-1:0] rx_wu_end;
    logic [TIME_W-1:0] tx_wd_end;
    logic [TIME_W-1:0] tx_wu_end;
  } end_word_t;
endpackage

// File: rtl/radio_seq_cfg.sv
module radio_seq_cfg
  import radio_seq_pkg::*;
#(
  parameter int unsigned NUM_SIG = 16,
  localparam int unsigned ADDR_W = $clog2(NUM_SIG + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WORD_W-1:0]         wdata_i,
  input  logic                      snap_i,
  output sig_word_t [NUM_SIG-1:0]   sig_o,
  output end_word_t                 end_o
);
  sig_word_t [NUM_SIG-1:0] live_q;
  end_word_t               live_end_q;

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[g] <= '1;
        sig_o[g]  <= '1;
      end else begin
        if (we_i && addr_i == ADDR_W'(g)) live_q[g] <= sig_word_t'(wdata_i);
        if (snap_i) sig_o[g] <= live_q[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_end_q <= '0;
      end_o      <= '0;
    end else begin
      if (we_i && addr_i == ADDR_W'(NUM_SIG)) live_end_q <= end_word_t'(wdata_i);
      if (snap_i) end_o <= live_end_q;
    end
  end
endmodule

// File: rtl/radio_seq_fsm.sv
module radio_seq_fsm
  import radio_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_req_i,
  input  logic              rx_req_i,
  input  logic              stop_req_i,
  input  logic              tick_i,
  input  end_word_t         end_i,
  output seq_state_e        state_o,
  output logic              is_tx_o,
  output logic [TIME_W-1:0] cnt_o,
  output logic              start_o,
  output logic              eval_o,
  output logic              finish_o
);
  logic [TIME_W-1:0] wu_end, wd_end;

  assign wu_end   = is_tx_o ? end_i.tx_wu_end : end_i.rx_wu_end;
  assign wd_end   = is_tx_o ? end_i.tx_wd_end : end_i.rx_wd_end;
  assign start_o  = (state_o == ST_IDLE) && (tx_req_i || rx_req_i);
  assign eval_o   = tick_i && (state_o == ST_WARMUP || state_o == ST_WARMDOWN);
  assign finish_o = eval_o && (state_o == ST_WARMDOWN) && (cnt_o == wd_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      is_tx_o <= 1'b0;
      cnt_o   <= '0;
    end else begin
      unique case (state_o)
        ST_IDLE: if (start_o) begin
          state_o <= ST_WARMUP;
          is_tx_o <= tx_req_i;  // TX wins a tie
          cnt_o   <= '0;
        end
        ST_WARMUP: if (tick_i) begin
          cnt_o <= cnt_o + 1'b1;
          if (cnt_o == wu_end) state_o <= ST_ACTIVE;
        end
        ST_ACTIVE: if (stop_req_i) state_o <= ST_WARMDOWN;
        ST_WARMDOWN: if (tick_i) begin
          if (cnt_o == wd_end) state_o <= ST_IDLE;
          else cnt_o <= cnt_o + 1'b1;
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radio_seq_lane.sv
module radio_seq_lane
  import radio_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sig_word_t         word_i,
  input  logic              is_tx_i,
  input  logic [TIME_W-1:0] cnt_i,
  input  logic              eval_i,
  input  logic              clear_i,
  output logic              en_o
);
  logic [TIME_W-1:0] on_t, off_t;
  logic hit_on, hit_off;

  assign on_t    = is_tx_i ? word_i.tx_on  : word_i.rx_on;
  assign off_t   = is_tx_i ? word_i.tx_off : word_i.rx_off;
  assign hit_on  = (on_t  != EDGE_OFF) && (cnt_i == on_t);
  assign hit_off = (off_t != EDGE_OFF) && (cnt_i == off_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= 1'b0;
    else if (clear_i) en_o <= 1'b0;
    else if (eval_i) begin
      if (hit_off)     en_o <= 1'b0;  // off wins over on
      else if (hit_on) en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/radio_seq_ctrl.sv
module radio_seq_ctrl
  import radio_seq_pkg::*;
#(
  parameter int unsigned NUM_SIG = 16,
  localparam int unsigned ADDR_W = $clog2(NUM_SIG + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic               tx_req_i,
  input  logic               rx_req_i,
  input  logic               stop_req_i,
  input  logic               tick_i,
  output logic [NUM_SIG-1:0] en_o,
  output logic [1:0]         state_o,
  output logic               ready_o
);
  sig_word_t [NUM_SIG-1:0] sig_words;
  end_word_t               end_word;
  seq_state_e              state;
  logic                    is_tx, start, eval, finish;
  logic [TIME_W-1:0]       cnt;

  radio_seq_cfg #(.NUM_SIG(NUM_SIG)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .snap_i  (start),
    .sig_o   (sig_words),
    .end_o   (end_word)
  );

  radio_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_req_i   (tx_req_i),
    .rx_req_i   (rx_req_i),
    .stop_req_i (stop_req_i),
    .tick_i     (tick_i),
    .end_i      (end_word),
    .state_o    (state),
    .is_tx_o    (is_tx),
    .cnt_o      (cnt),
    .start_o    (start),
    .eval_o     (eval),
    .finish_o   (finish)
  );

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_lane
    radio_seq_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .word_i  (sig_words[g]),
      .is_tx_i (is_tx),
      .cnt_i   (cnt),
      .eval_i  (eval),
      .clear_i (finish || start),
      .en_o    (en_o[g])
    );
  end

  assign state_o = state;
  assign ready_o = (state == ST_ACTIVE);
endmodule

// File: rtl/radio_seq_chk.sv
module radio_seq_chk #(
  parameter int unsigned NUM_SIG = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [NUM_SIG-1:0] en_o,
  input logic [1:0]         state_o
);
  a_r3_edges_need_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(en_o));

  a_r6_idle_lines_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |-> en_o == '0);

  a_r4_hold_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) == 2'd2) |-> $stable(en_o));

  a_r4_warmup_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 |=> (state_o == 2'd1 || state_o == 2'd2));

  a_r5_active_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |=> (state_o == 2'd2 || state_o == 2'd3));

  a_r6_warmdown_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |=> (state_o == 2'd3 || state_o == 2'd0));
endmodule

bind radio_seq_ctrl radio_seq_chk #(.NUM_SIG(NUM_SIG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .en_o    (en_o),
  .state_o (state_o)
);

// File: tb/radio_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module radio_seq_ctrl_tb_top;
  localparam int NUM_SIG = 16;
  localparam int ADDR_W  = $clog2(NUM_SIG + 1);
  localparam int NROWS   = 27;
  // row: [7:6] action (0 none, 1 tx, 2 rx, 3 stop), [5:4] state, [3:0] en[3:0]
  localparam logic [7:0] VEC [NROWS] = '{
    8'b01_01_0001, 8'b00_01_0001, 8'b00_01_0001, 8'b00_01_0011, 8'b00_01_0001,
    8'b00_01_0101, 8'b00_01_0101, 8'b00_01_0101, 8'b00_01_0101, 8'b00_01_0101,
    8'b00_10_0101, 8'b11_11_0001, 8'b00_11_0001, 8'b00_11_0001, 8'b00_00_0000,
    8'b10_01_0001, 8'b00_01_1001, 8'b00_01_1001, 8'b00_01_1001, 8'b00_01_1001,
    8'b00_01_0001, 8'b00_01_0001, 8'b00_01_0001, 8'b00_10_0001, 8'b11_11_0001,
    8'b00_11_0001, 8'b00_00_0000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic tx_req = 1'b0, rx_req = 1'b0, stop_req = 1'b0, tick = 1'b0;
  logic [NUM_SIG-1:0] en;
  logic [1:0] state;
  logic ready;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  radio_seq_ctrl #(.NUM_SIG(NUM_SIG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .tx_req_i(tx_req), .rx_req_i(rx_req),
    .stop_req_i(stop_req), .tick_i(tick), .en_o(en), .state_o(state), .ready_o(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic act(input logic [1:0] code);
    @(negedge clk);
    tx_req = (code == 2'd1); rx_req = (code == 2'd2); stop_req = (code == 2'd3);
    @(negedge clk); tx_req = 1'b0; rx_req = 1'b0; stop_req = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 en", 32'(en), 32'h0);
    check("R9 state", 32'(state), 32'd0);
    check("R9 ready", 32'(ready), 32'd0);
    rst_n = 1'b1;
    // R1/R2/R10 programming: line0 on 0/off 14 TX, on 0 RX; line1 TX pulse 3..4, RX off;
    // line2 TX 5..11, RX on=off=2; line3 TX off, RX 1..5
    wr(0, 32'hFF00_0E00);
    wr(1, 32'hFFFF_0403);
    wr(2, 32'h0202_0B05);
    wr(3, 32'h0501_FFFF);
    wr(NUM_SIG, 32'h0B08_0E0A);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NROWS; i++) begin
      if (VEC[i][7:6] != 2'd0) act(VEC[i][7:6]);
      do_tick();
      check($sformatf("R3 row%0d en", i), 32'(en), {28'h0, VEC[i][3:0]});
      check($sformatf("R4 row%0d state", i), 32'(state), {30'h0, VEC[i][5:4]});
      check($sformatf("R4 row%0d ready", i), 32'(ready), 32'(VEC[i][5:4] == 2'd2));
    end

    // R7 both requests: TX wins (k1 TX=0001, RX would be 1001)
    @(negedge clk); tx_req = 1'b1; rx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; rx_req = 1'b0;
    do_tick(); do_tick();
    check("R7 tie picks tx", 32'(en), 32'h1);
    // R8 rewrite line1 mid-sequence; R7 rx_req ignored; R5 stop ignored in warmup
    wr(1, 32'hFFFF_0201);
    act(2'd2);
    act(2'd3);
    check("R5 stop ignored in warmup", 32'(state), 32'd1);
    repeat (5) @(negedge clk);
    check("R3 no tick no change", 32'(en), 32'h1);
    do_tick();
    check("R7 rx_req ignored k2", 32'(en), 32'h1);
    do_tick();
    check("R8 old word still used k3", 32'(en), 32'h3);
    for (int k = 4; k <= 10; k++) do_tick();
    check("R4 active reached", 32'(state), 32'd2);
    do_tick(); do_tick(); do_tick();
    check("R4 ticks ignored in active en", 32'(en), 32'h5);
    check("R4 ticks ignored in active state", 32'(state), 32'd2);
    check("R4 ready high", 32'(ready), 32'd1);
    act(2'd3);
    do_tick();
    check("R5 warmdown resumes at wu_end+1", 32'(en), 32'h1);
    do_tick(); do_tick(); do_tick();
    check("R6 end forces low", 32'(en), 32'h0);
    check("R6 back to idle", 32'(state), 32'd0);

    // R8 new word visible on next start
    act(2'd1);
    do_tick(); do_tick();
    check("R8 new word k1", 32'(en), 32'h3);
    do_tick();
    check("R8 new word k2", 32'(en), 32'h1);
    for (int k = 3; k <= 10; k++) do_tick();
    act(2'd3);
    for (int k = 11; k <= 14; k++) do_tick();
    check("R6 idle after second run", 32'(state), 32'd0);
    act(2'd3);
    check("R5 stop ignored in idle", 32'(state), 32'd0);
    check("R6 lines low in idle", 32'(en), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule